// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

This peripheral generates up to four independent pulse trains behind a small 32-bit register bus that follows APB write timing (select, then enable) and decodes reads in the select cycle. Each channel produces a period made of a high phase followed by a low phase. Both phase lengths come from a single packed reload word. A new reload word is picked up only when a period finishes, so software can retune a running channel without glitches.

Each channel counts either on every bus-clock cycle or on a single-cycle tick-enable input that stands for a slower external clock. A channel runs only while its enable bit and its PWM-mode bit are both set. When it stops, the output falls at once to a per-channel idle ("park") level. The park level is also the only way to hold a steady 0 or 1, because a running channel always has at least one tick of each phase.

If the clock source is switched on a running channel, that channel's output is held at the park level until software rewrites the reload register. That write restarts the channel with a fresh high phase.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads zero and every output is low.
- R2: Offset 0x1C holds the shared enables, with channel n's bit at position 3+4n. Channel n has its control word at 0x20+0x10n (bits 4:0 writable and read back), its reload word at 0x24+0x10n (all 32 bits read back) and its counter at 0x28+0x10n.
- R3: A running channel drives high for (reload[31:16]+1) ticks, then low for (reload[15:0]+1) ticks, and repeats. Enabling starts a fresh high phase one cycle after the enabling write.
- R4: Control bit 3 selects the time base. A 1 counts on every bus-clock cycle. A 0 counts only in cycles where the external tick input is 1.
- R5: The counter register reads the live down-count of the current phase, and writes to it have no effect.
- R6: A reload word written while a channel runs leaves the current period as it is and applies from the next period.
- R7: When a channel stops, its output takes the park level (control bit 4) in the very next cycle, without finishing the period.
- R8: A channel with control bit 2 (PWM mode) clear stays stopped and parked even while its enable bit is set.
- R9: Changing bit 3 on a running channel parks its output until the reload register is written. One cycle after that write, a fresh high phase begins.
- R10: Reads of unmapped offsets return zero.
- R11: Channels are independent: running one leaves the others parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase of a write |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high and pwrite is low |
| extTick | input | 1 | External time-base tick, one bus cycle wide |
| pwmOut | output | 4 | Channel outputs |

## Verification
The assertions assume the following about the inputs:
- extTick is synchronous to the bus clock.
- A write is a select cycle followed by exactly one enable cycle.
- A channel never gets a start and a stop in the same cycle.

The bench drives every input on the falling edge and frames each write as one select cycle plus one enable cycle. It changes enables only through whole register writes. It drives extTick for exactly one cycle per tick, so counts on the external time base are stepped one at a time.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DATA_W   = 32;
  localparam int PHASE_W  = 16;
  localparam int CTRL_W   = 5;
  localparam int MODE_BIT = 2;
  localparam int SRC_BIT  = 3;
  localparam int PARK_BIT = 4;

  typedef struct packed {
    logic start;
    logic stop;
    logic restart;
    logic hold;
  } chStb_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             psel,
  input  logic                             penable,
  input  logic                             pwrite,
  input  logic [ADDR_W-1:0]                paddr,
  input  logic [DATA_W-1:0]                pwdata,
  output logic [DATA_W-1:0]                prdata,
  input  logic [NUM_CH-1:0][PHASE_W-1:0]   cntArr,
  output chStb_t [NUM_CH-1:0]              stbArr,
  output logic [NUM_CH-1:0]                activeArr,
  output logic [NUM_CH-1:0]                parkArr,
  output logic [NUM_CH-1:0]                srcBusArr,
  output logic [NUM_CH-1:0][DATA_W-1:0]    reloadArr
);
  localparam int EN_OFF    = 'h1C;
  localparam int CH_BASE   = 'h20;
  localparam int SEL_W     = ADDR_W - 4;
  localparam int EN_FIRST  = 3;
  localparam int EN_STRIDE = 4;

  logic [NUM_CH-1:0]             enQ, activeQ, dirtyQ, restartQ;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrlQ;
  logic [NUM_CH-1:0][DATA_W-1:0] reloadQ;
  logic [NUM_CH-1:0]             selCh;
  logic                          wrStb, enHit;
  logic [3:0]                    sub;

  assign wrStb = psel & penable & pwrite;
  assign enHit = (paddr == ADDR_W'(EN_OFF));
  assign sub   = paddr[3:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign selCh[g] = (paddr[ADDR_W-1:4] == SEL_W'(CH_BASE / 16 + g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ      <= '0;
      activeQ  <= '0;
      dirtyQ   <= '0;
      restartQ <= '0;
      ctrlQ    <= '0;
      reloadQ  <= '0;
    end else begin
      activeQ  <= activeArr;
      restartQ <= '0;
      for (int n = 0; n < NUM_CH; n++) begin
        if (restartQ[n] || !activeArr[n]) dirtyQ[n] <= 1'b0;
        if (wrStb && enHit) enQ[n] <= pwdata[EN_FIRST + EN_STRIDE * n];
        if (wrStb && selCh[n] && sub == 4'h0) begin
          ctrlQ[n] <= pwdata[CTRL_W-1:0];
          if (activeArr[n] && (pwdata[SRC_BIT] != ctrlQ[n][SRC_BIT])) dirtyQ[n] <= 1'b1;
        end
        if (wrStb && selCh[n] && sub == 4'h4) begin
          reloadQ[n] <= pwdata;
          if (dirtyQ[n]) restartQ[n] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      activeArr[n]      = enQ[n] & ctrlQ[n][MODE_BIT];
      parkArr[n]        = ctrlQ[n][PARK_BIT];
      srcBusArr[n]      = ctrlQ[n][SRC_BIT];
      reloadArr[n]      = reloadQ[n];
      stbArr[n].start   = activeArr[n] & ~activeQ[n];
      stbArr[n].stop    = ~activeArr[n] & activeQ[n];
      stbArr[n].restart = restartQ[n];
      stbArr[n].hold    = dirtyQ[n];
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (enHit) begin
        for (int n = 0; n < NUM_CH; n++) prdata[EN_FIRST + EN_STRIDE * n] = enQ[n];
      end
      for (int n = 0; n < NUM_CH; n++) begin
        if (selCh[n]) begin
          case (sub)
            4'h0:    prdata = DATA_W'(ctrlQ[n]);
            4'h4:    prdata = reloadQ[n];
            4'h8:    prdata = DATA_W'(cntArr[n]);
            default: prdata = '0;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R9
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (dirtyQ[g] && !activeArr[g]) |=> !dirtyQ[g]);
    // R9
    restart_once_chk: assert property (@(posedge clk) disable iff (!rstN)
      restartQ[g] |=> !restartQ[g] && !dirtyQ[g]);
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  chStb_t             stb,
  input  logic               active,
  input  logic               park,
  input  logic               srcBus,
  input  logic               extTick,
  input  logic [DATA_W-1:0]  reloadWord,
  output logic [PHASE_W-1:0] cnt,
  output logic               pwmOut
);
  logic               runQ, highQ, tick, loadNow;
  logic [PHASE_W-1:0] cntQ, lowShadowQ, reloadHigh, reloadLow;

  assign reloadHigh = reloadWord[DATA_W-1 -: PHASE_W];
  assign reloadLow  = reloadWord[PHASE_W-1:0];
  assign tick       = srcBus | extTick;
  assign loadNow    = stb.start | stb.restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ       <= 1'b0;
      highQ      <= 1'b0;
      cntQ       <= '0;
      lowShadowQ <= '0;
    end else if (stb.stop) begin
      runQ <= 1'b0;
    end else if (loadNow) begin
      runQ       <= 1'b1;
      highQ      <= 1'b1;
      cntQ       <= reloadHigh;
      lowShadowQ <= reloadLow;
    end else if (runQ && tick) begin
      if (cntQ == '0) begin
        if (highQ) begin
          highQ <= 1'b0;
          cntQ  <= lowShadowQ;
        end else begin
          highQ      <= 1'b1;
          cntQ       <= reloadHigh;
          lowShadowQ <= reloadLow;
        end
      end else begin
        cntQ <= cntQ - PHASE_W'(1);
      end
    end
  end

  assign cnt    = cntQ;
  assign pwmOut = (runQ && active && !stb.hold) ? highQ : park;

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadNow && !stb.stop) |=> runQ && highQ && (cntQ == $past(reloadHigh)));
  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && tick && cntQ != '0 && !loadNow && !stb.stop) |=> cntQ == $past(cntQ) - PHASE_W'(1));
  // R4
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !srcBus && !extTick && !loadNow && !stb.stop) |=> $stable(cntQ) && $stable(highQ));
  // R7
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stop |=> !runQ);
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              extTick,
  output logic [NUM_CH-1:0] pwmOut
);
  chStb_t [NUM_CH-1:0]            stbArr;
  logic [NUM_CH-1:0]              activeArr, parkArr, srcBusArr;
  logic [NUM_CH-1:0][DATA_W-1:0]  reloadArr;
  logic [NUM_CH-1:0][PHASE_W-1:0] cntArr;

  pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cntArr(cntArr),
    .stbArr(stbArr), .activeArr(activeArr), .parkArr(parkArr),
    .srcBusArr(srcBusArr), .reloadArr(reloadArr)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel u_ch (
      .clk(clk), .rstN(rstN), .stb(stbArr[g]), .active(activeArr[g]),
      .park(parkArr[g]), .srcBus(srcBusArr[g]), .extTick(extTick),
      .reloadWord(reloadArr[g]), .cnt(cntArr[g]), .pwmOut(pwmOut[g])
    );
  end
endmodule

// File: tb/test_pwm_quad.sv
module test_pwm_quad;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, extTick = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [3:0]  pwmOut;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  pwm_quad i_pwm_quad (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .extTick(extTick), .pwmOut(pwmOut)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    #1 d = prdata;
    psel = 0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tickExt();
    @(negedge clk); extTick = 1;
    @(negedge clk); extTick = 0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R1 outputs", 32'(pwmOut), 0);
    rd(8'h1C, d); chk("R1 enable", d, 0);
    rd(8'h20, d); chk("R1 ctrl0", d, 0);
    rd(8'h24, d); chk("R1 reload0", d, 0);
    rd(8'h28, d); chk("R1 counter0", d, 0);
    rd(8'h54, d); chk("R1 reload3", d, 0);
  endtask

  task automatic testRegMap();
    logic [31:0] d;
    wr(8'h50, 32'h3F);       rd(8'h50, d); chk("R2 ctrl field", d, 32'h1F);
    wr(8'h54, 32'hDEADBEEF); rd(8'h54, d); chk("R2 reload word", d, 32'hDEADBEEF);
    wr(8'h1C, 32'hFFFFFFFF); rd(8'h1C, d); chk("R2 enable bits", d, 32'h8888);
    wr(8'h1C, 0); wr(8'h50, 0);
  endtask

  task automatic testBusWave();
    wr(8'h20, 32'h0C); wr(8'h24, {16'd2, 16'd1}); wr(8'h1C, 32'h8);
    chk("R3 not yet started", 32'(pwmOut[0]), 0);
    for (int i = 0; i < 10; i++) begin
      step(1);
      chk("R3 R4 bus waveform", 32'(pwmOut[0]), ((i % 5) < 3) ? 1 : 0);
    end
    wr(8'h1C, 0); wr(8'h20, 0);
  endtask

  task automatic testDisable();
    wr(8'h24, {16'd7, 16'd7}); wr(8'h20, 32'h0C); wr(8'h1C, 32'h8);
    wr(8'h1C, 0);
    chk("R7 immediate park low", 32'(pwmOut[0]), 0);
    wr(8'h20, 32'h1C); wr(8'h24, {16'd0, 16'd15}); wr(8'h1C, 32'h8);
    wr(8'h1C, 0);
    chk("R7 immediate park high", 32'(pwmOut[0]), 1);
    wr(8'h20, 0);
    chk("R7 park follows bit4", 32'(pwmOut[0]), 0);
  endtask

  task automatic testExt();
    logic [31:0] d;
    wr(8'h30, 32'h04); wr(8'h34, {16'd3, 16'd2}); wr(8'h1C, 32'h80);
    step(1);
    rd(8'h38, d); chk("R5 counter at start", d, 3);
    chk("R3 ext high phase", 32'(pwmOut[1]), 1);
    chk("R11 other channel parked", 32'(pwmOut[0]), 0);
    rd(8'h1C, d); chk("R2 ch1 enable bit7", d, 32'h80);
    tickExt();
    rd(8'h38, d); chk("R4 one tick", d, 2);
    step(5);
    rd(8'h38, d); chk("R4 no tick no count", d, 2);
    chk("R4 still high", 32'(pwmOut[1]), 1);
    repeat (3) tickExt();
    chk("R3 ext low phase", 32'(pwmOut[1]), 0);
    rd(8'h38, d); chk("R5 low count loaded", d, 2);
    wr(8'h38, 32'hFFFF);
    rd(8'h38, d); chk("R5 counter write ignored", d, 2);
  endtask

  task automatic testReload();
    logic [31:0] d;
    wr(8'h34, 0);
    tickExt(); tickExt();
    chk("R6 old low kept", 32'(pwmOut[1]), 0);
    rd(8'h38, d); chk("R6 old low count", d, 0);
    tickExt();
    chk("R6 new period high", 32'(pwmOut[1]), 1);
    rd(8'h38, d); chk("R6 new high count", d, 0);
    tickExt(); chk("R3 one-tick low", 32'(pwmOut[1]), 0);
    tickExt(); chk("R3 one-tick high", 32'(pwmOut[1]), 1);
  endtask

  task automatic testSrcChange();
    wr(8'h30, 32'h0C);
    for (int i = 0; i < 6; i++) begin
      chk("R9 parked after source change", 32'(pwmOut[1]), 0);
      step(1);
    end
    wr(8'h34, {16'd4, 16'd4});
    chk("R9 parked until restart", 32'(pwmOut[1]), 0);
    step(1); chk("R9 fresh high", 32'(pwmOut[1]), 1);
    step(4); chk("R9 high fifth", 32'(pwmOut[1]), 1);
    step(1); chk("R9 low after five", 32'(pwmOut[1]), 0);
    wr(8'h1C, 0); wr(8'h30, 0);
  endtask

  task automatic testMode();
    wr(8'h40, 32'h18); wr(8'h44, {16'd1, 16'd1}); wr(8'h1C, 32'h800);
    for (int i = 0; i < 4; i++) begin
      step(1);
      chk("R8 mode off parked", 32'(pwmOut[2]), 1);
    end
    wr(8'h40, 32'h1C);
    step(3); chk("R8 mode on low phase", 32'(pwmOut[2]), 0);
    step(2); chk("R8 mode on high again", 32'(pwmOut[2]), 1);
    wr(8'h1C, 0); wr(8'h40, 0);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    rd(8'h00, d); chk("R10 offset 00", d, 0);
    rd(8'h2C, d); chk("R10 offset 2C", d, 0);
    rd(8'h60, d); chk("R10 offset 60", d, 0);
    rd(8'h1D, d); chk("R10 offset 1D", d, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    step(3);
    rstN = 1;
    step(1);
    testReset();
    testRegMap();
    testBusWave();
    testDisable();
    testExt();
    testReload();
    testSrcChange();
    testMode();
    testUnmapped();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule